// File: doc/BRIEF.md
# Single-Wire Entry and Synchronization Detector

This block listens to one sampled open-drain debug line and recognises two special line conditions that are not data bits. The first is an activation entry pattern: eight pulses in which the last four have half the period of the first four. The second is a synchronization low, which is a low phase whose length falls inside a programmable window. All timing is measured in cycles of the sampling clock. The line is passed through a two-flop synchronizer before its edges are detected.

The entry pattern is matched by relative timing, not against a fixed frequency. The rise-to-rise period of the first pulse becomes the reference. Each later pulse of the first group must lie within two samples of that reference. After the fourth pulse the reference is halved, and the next four pulses must match the halved value. When a pulse does not match, the progress is discarded and that pulse becomes the first pulse of a new candidate. A completed pattern gives a one-cycle `active_o` pulse.

A synchronization low whose length lies inside the window has three results. It gives a one-cycle `sync_o`, a one-cycle `proto_rst_o` that returns the downstream protocol logic to its idle, low-speed state, and a new line-clock period estimate. The estimate treats the measured low as exactly 128 line clocks. The window limits are supplied as sample counts by the integrator. The integrator computes them from the nominal line clock: the lower limit uses the fastest clock and the upper limit uses the slowest clock. Decoding of bits and bytes is not part of this block, and neither is driving the line.

Top module: `swl_entry_sync_det`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `active_o`, `sync_o` and `proto_rst_o` are 0 and `clk_period_o` is 0.
- R2: `line_in` passes through two flip-flops. A level applied before clock edge k is detected as an edge at edge k+1, and any pulse it causes is visible after edge k+2.
- R3: Take eight consecutive rise-to-rise periods. The first is the reference. Periods 2 to 4 each differ from the reference by at most 2. Periods 5 to 8 each differ from floor(reference/2) by at most 2. When all of this holds, `active_o` is high for exactly one cycle, at the rising edge that ends period 8.
- R4: A period that differs from the value it is compared with by 3 or more restarts matching, and that same period becomes the new reference (period 1).
- R5: A low phase (falling edge to rising edge) of length L sample cycles with `sync_min_i` <= L <= `sync_max_i` (both limits inclusive) gives one cycle of `sync_o` at the closing rising edge. Lengths outside the window give no pulse.
- R6: On each valid synchronization low, `clk_period_o` becomes L >> (7 - FRAC_BITS). This is the line-clock period in sample cycles with FRAC_BITS fraction bits, since L counts 128 line clocks. Otherwise `clk_period_o` holds its value.
- R7: `proto_rst_o` is high in exactly the cycles in which `sync_o` is high.
- R8: Period and low-length counters saturate at 2^CNT_W - 1 and do not wrap.
- R9: A period is measured only between two rising edges seen after reset. The first rising edge after reset starts timing but is not matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw debug line level, idle high |
| sync_min_i | input | CNT_W | Shortest valid synchronization low, in sample cycles |
| sync_max_i | input | CNT_W | Longest valid synchronization low, in sample cycles |
| active_o | output | 1 | One-cycle pulse on a complete entry pattern |
| sync_o | output | 1 | One-cycle pulse on a valid synchronization low |
| proto_rst_o | output | 1 | One-cycle reset request to the downstream protocol logic |
| clk_period_o | output | CNT_W | Line-clock period estimate, FRAC_BITS fraction bits |

## Verification
Every result of this block appears after the third clock edge that samples the new line level. That edge is two synchronizer stages plus the registered output stage. It falls on the rising edge that ends a period or a low phase. The estimate is updated at the same edge as `sync_o`.

The bench's behavioural model applies the same three-edge delay to its own integer history of the line. Outputs are compared at the falling clock edge that follows each rising edge. One directed check counts negative edges after the line is released, so that the sync pulse is confirmed on exactly the third edge.

// File: rtl/swl_pkg.sv
package swl_pkg;
  // A measured interval is compared with its reference using this tolerance.
  localparam int unsigned SWL_TOL = 2;
  // A synchronization low is defined as this many line clocks (log2).
  localparam int unsigned SWL_SYNC_LOG2 = 7;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } swl_edge_t;
endpackage

// File: rtl/swl_line_sync.sv
module swl_line_sync
  import swl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      line_in,
  output swl_edge_t edge_o
);
  logic meta_q, stab_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_in;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  always_comb begin
    edge_o.level = stab_q;
    edge_o.rise  = stab_q & ~prev_q;
    edge_o.fall  = ~stab_q & prev_q;
  end
endmodule

// File: rtl/swl_interval_meter.sv
module swl_interval_meter
  import swl_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  swl_edge_t        edge_i,
  output logic             per_vld_o,
  output logic [CNT_W-1:0] per_len_o,
  output logic             low_vld_o,
  output logic [CNT_W-1:0] low_len_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] per_q, low_q;
  logic             seen_q, armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= '0;
      seen_q  <= 1'b0;
      low_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (edge_i.rise) begin
        per_q  <= CNT_W'(1);
        seen_q <= 1'b1;
      end else if (per_q != CNT_MAX) begin
        per_q <= per_q + 1'b1;
      end

      if (edge_i.fall) begin
        low_q   <= CNT_W'(1);
        armed_q <= 1'b1;
      end else if (edge_i.rise) begin
        armed_q <= 1'b0;
      end else if (!edge_i.level && armed_q && low_q != CNT_MAX) begin
        low_q <= low_q + 1'b1;
      end
    end
  end

  assign per_vld_o = edge_i.rise & seen_q;
  assign per_len_o = per_q;
  assign low_vld_o = edge_i.rise & armed_q;
  assign low_len_o = low_q;
endmodule

// File: rtl/swl_entry_matcher.sv
module swl_entry_matcher
  import swl_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned GROUP_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             per_vld_i,
  input  logic [CNT_W-1:0] per_len_i,
  output logic             active_o
);
  localparam int unsigned TOTAL = 2 * GROUP_LEN;
  localparam int unsigned IDX_W = $clog2(TOTAL);

  logic [CNT_W-1:0] ref_q, diff;
  logic [IDX_W-1:0] idx_q;
  logic             mismatch, act_q;

  always_comb begin
    diff     = (per_len_i > ref_q) ? (per_len_i - ref_q) : (ref_q - per_len_i);
    mismatch = diff > CNT_W'(SWL_TOL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= 1'b0;
      if (per_vld_i) begin
        if (idx_q == '0 || mismatch) begin
          ref_q <= per_len_i;
          idx_q <= IDX_W'(1);
        end else if (idx_q < IDX_W'(GROUP_LEN)) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(GROUP_LEN - 1))
            ref_q <= ref_q >> 1;
        end else if (idx_q == IDX_W'(TOTAL - 1)) begin
          idx_q <= '0;
          act_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/swl_sync_judge.sv
module swl_sync_judge
  import swl_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned FRAC_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             low_vld_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] win_min_i,
  input  logic [CNT_W-1:0] win_max_i,
  output logic             sync_o,
  output logic             proto_rst_o,
  output logic [CNT_W-1:0] period_o
);
  localparam int unsigned SHIFT = SWL_SYNC_LOG2 - FRAC_BITS;

  logic             in_win;
  logic             sync_q, prst_q;
  logic [CNT_W-1:0] est_q;

  assign in_win = (low_len_i >= win_min_i) && (low_len_i <= win_max_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      prst_q <= 1'b0;
      est_q  <= '0;
    end else begin
      sync_q <= low_vld_i & in_win;
      prst_q <= low_vld_i & in_win;
      if (low_vld_i && in_win)
        est_q <= low_len_i >> SHIFT;
    end
  end

  assign sync_o      = sync_q;
  assign proto_rst_o = prst_q;
  assign period_o    = est_q;
endmodule

// File: rtl/swl_entry_sync_det.sv
module swl_entry_sync_det
  import swl_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned FRAC_BITS = 4,
  parameter int unsigned GROUP_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic [CNT_W-1:0] sync_min_i,
  input  logic [CNT_W-1:0] sync_max_i,
  output logic             active_o,
  output logic             sync_o,
  output logic             proto_rst_o,
  output logic [CNT_W-1:0] clk_period_o
);
  swl_edge_t        edge_s;
  logic             per_vld, low_vld;
  logic [CNT_W-1:0] per_len, low_len;

  swl_line_sync u_sync (
    .clk(clk), .rst(rst), .line_in(line_in), .edge_o(edge_s)
  );

  swl_interval_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .edge_i(edge_s),
    .per_vld_o(per_vld), .per_len_o(per_len),
    .low_vld_o(low_vld), .low_len_o(low_len)
  );

  swl_entry_matcher #(.CNT_W(CNT_W), .GROUP_LEN(GROUP_LEN)) u_match (
    .clk(clk), .rst(rst), .per_vld_i(per_vld), .per_len_i(per_len),
    .active_o(active_o)
  );

  swl_sync_judge #(.CNT_W(CNT_W), .FRAC_BITS(FRAC_BITS)) u_judge (
    .clk(clk), .rst(rst), .low_vld_i(low_vld), .low_len_i(low_len),
    .win_min_i(sync_min_i), .win_max_i(sync_max_i),
    .sync_o(sync_o), .proto_rst_o(proto_rst_o), .period_o(clk_period_o)
  );
endmodule

// File: rtl/swl_entry_sync_chk.sv
module swl_entry_sync_chk #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned FRAC_BITS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] sync_min_i,
  input logic [CNT_W-1:0] sync_max_i,
  input logic             active_o,
  input logic             sync_o,
  input logic             proto_rst_o,
  input logic [CNT_W-1:0] clk_period_o
);
  localparam int unsigned SH = 7 - FRAC_BITS;

  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!active_o && !sync_o && !proto_rst_o && clk_period_o == '0)); // R1
  AST_ACTIVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    active_o |=> !active_o); // R3
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o); // R5
  AST_EST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> ((clk_period_o >= (sync_min_i >> SH)) && (clk_period_o <= (sync_max_i >> SH)))); // R6
  AST_EST_HOLD: assert property (@(posedge clk) disable iff (rst || !live_q)
    !sync_o |-> $stable(clk_period_o)); // R6
  AST_PROTO_WITH_SYNC: assert property (@(posedge clk) disable iff (rst)
    proto_rst_o == sync_o); // R7
endmodule

bind swl_entry_sync_det swl_entry_sync_chk #(.CNT_W(CNT_W), .FRAC_BITS(FRAC_BITS)) u_chk (
  .clk(clk), .rst(rst), .sync_min_i(sync_min_i), .sync_max_i(sync_max_i),
  .active_o(active_o), .sync_o(sync_o), .proto_rst_o(proto_rst_o),
  .clk_period_o(clk_period_o)
);

// File: tb/swl_entry_sync_det_tb.sv
`timescale 1ns/1ps
module swl_entry_sync_det_tb_top;
  localparam int CNT_W = 12;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1, line_in = 1'b1;
  logic [CNT_W-1:0] sync_min_i = 12'd100, sync_max_i = 12'd300;
  logic active_o, sync_o, proto_rst_o;
  logic [CNT_W-1:0] clk_period_o;

  always #10 clk = ~clk;

  swl_entry_sync_det #(.CNT_W(CNT_W), .FRAC_BITS(4), .GROUP_LEN(4)) dut_i (
    .clk(clk), .rst(rst), .line_in(line_in), .sync_min_i(sync_min_i),
    .sync_max_i(sync_max_i), .active_o(active_o), .sync_o(sync_o),
    .proto_rst_o(proto_rst_o), .clk_period_o(clk_period_o)
  );

  int compared = 0, mismatched = 0, cyc = 0, act_cnt = 0, sync_cnt = 0;
  bit started = 0, done = 0;

  // behavioural reference
  int ms1, ms2, ms3, per, low, refv, idx, e_act, e_sync, e_est;
  bit seen, lowv;

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      ms1 = 1; ms2 = 1; ms3 = 1; per = 0; low = 0; refv = 0; idx = 0;
      seen = 0; lowv = 0; e_act = 0; e_sync = 0; e_est = 0;
    end else begin
      bit rs, fl;
      int d;
      rs = (ms2 == 1) && (ms3 == 0);
      fl = (ms2 == 0) && (ms3 == 1);
      e_act = 0; e_sync = 0;
      if (rs && seen) begin
        d = (per > refv) ? per - refv : refv - per;
        if (idx == 0 || d > 2) begin refv = per; idx = 1; end
        else if (idx < 4) begin idx++; if (idx == 4) refv = refv / 2; end
        else begin idx++; if (idx == 8) begin e_act = 1; idx = 0; end end
      end
      if (rs) begin per = 1; seen = 1; end
      else if (per < MAXC) per++;
      if (rs && lowv) begin
        if (low >= int'(sync_min_i) && low <= int'(sync_max_i)) begin
          e_sync = 1; e_est = low >> 3;
        end
        lowv = 0;
      end
      if (fl) begin low = 1; lowv = 1; end
      else if (ms2 == 0 && lowv && low < MAXC) low++;
      ms3 = ms2; ms2 = ms1; ms1 = int'(line_in);
    end
  end

  task automatic cmp(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cmp("R3/R4/R9 active_o", int'(active_o), e_act);
      cmp("R5 sync_o", int'(sync_o), e_sync);
      cmp("R7 proto_rst_o", int'(proto_rst_o), e_sync);
      cmp("R6/R8 clk_period_o", int'(clk_period_o), e_est);
      if (active_o) act_cnt++;
      if (sync_o) sync_cnt++;
    end
  end

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  task automatic hold(int v, int n);
    line_in = v[0];
    repeat (n) @(negedge clk);
  endtask

  int iv_q[$];
  task automatic add_iv(int v); iv_q.push_back(v); endtask

  // rises spaced exactly by the queued intervals
  task automatic send_iv();
    hold(0, 3);
    foreach (iv_q[i]) begin hold(1, iv_q[i] - 3); hold(0, 3); end
    hold(1, 60);
    iv_q.delete();
  endtask

  task automatic expect_count(string tag, int got, int exp);
    cmp(tag, got, exp);
  endtask

  initial begin
    int a0, s0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cmp("R1 reset active", int'(active_o), 0);
    cmp("R1 reset est", int'(clk_period_o), 0);
    // R9: first rise after reset is ~20 cycles out but must not be matched
    hold(1, 14);
    a0 = act_cnt;
    for (int k = 0; k < 3; k++) add_iv(20);
    for (int k = 0; k < 4; k++) add_iv(10);
    send_iv();
    expect_count("R9 no match from reset", act_cnt - a0, 0);
    // R3 clean pattern
    a0 = act_cnt;
    for (int k = 0; k < 4; k++) add_iv(20);
    for (int k = 0; k < 4; k++) add_iv(10);
    send_iv();
    expect_count("R3 clean entry", act_cnt - a0, 1);
    // R3 tolerance edges of +-2
    a0 = act_cnt;
    add_iv(20); add_iv(22); add_iv(18); add_iv(20);
    add_iv(10); add_iv(12); add_iv(8); add_iv(10);
    send_iv();
    expect_count("R3 tolerance", act_cnt - a0, 1);
    // R4 mismatch restarts on the offending pulse
    a0 = act_cnt;
    add_iv(20); add_iv(23);
    for (int k = 0; k < 4; k++) add_iv(20);
    for (int k = 0; k < 4; k++) add_iv(10);
    send_iv();
    expect_count("R4 restart then match", act_cnt - a0, 1);
    a0 = act_cnt;
    for (int k = 0; k < 4; k++) add_iv(20);
    add_iv(10); add_iv(10); add_iv(13); add_iv(10); add_iv(10);
    send_iv();
    expect_count("R4 second group break", act_cnt - a0, 0);
    // R5 window edges
    s0 = sync_cnt;
    hold(0, 99);  hold(1, 40);
    hold(0, 100); hold(1, 40);
    hold(0, 300); hold(1, 40);
    hold(0, 301); hold(1, 40);
    expect_count("R5 window inclusive", sync_cnt - s0, 2);
    // R2 latency and R6 estimate
    hold(0, 256);
    line_in = 1'b1;
    @(negedge clk); cmp("R2 no pulse at edge 1", int'(sync_o), 0);
    @(negedge clk); cmp("R2 no pulse at edge 2", int'(sync_o), 0);
    @(negedge clk); cmp("R2 pulse at edge 3", int'(sync_o), 1);
    cmp("R6 estimate 256>>3", int'(clk_period_o), 32);
    hold(1, 20); hold(0, 50); hold(1, 40);
    cmp("R6 hold after short low", int'(clk_period_o), 32);
    // R8 saturation of the low counter
    sync_max_i = 12'd4095;
    hold(1, 10); hold(0, 5000); hold(1, 40);
    cmp("R8 saturated estimate", int'(clk_period_o), 511);
    sync_max_i = 12'd300;
    hold(1, 20);
    summary();
  end
endmodule